// File: doc/BRIEF.md
# Per-Line HDMA Trigger Scheduler

This block decides, once per scanline, whether the horizontal-blank transfer channels start moving data. It watches the horizontal master-clock counter and a scanline-start strobe. It keeps a software-written 8-bit channel-enable register and a per-frame "completed" flag for each channel. When the counter reaches the trigger position and at least one channel is enabled and not completed, it raises a request toward the transfer engine and marks the run as a per-line transfer. The other mode value is setup.

The enable bits that decide a line are not read at the trigger position. They are captured a parameterised number of master clocks earlier. A CPU write that lands inside that lead window therefore acts only on the next line. Before the engine may start, the scheduler pads the start onto the 8-clock DMA grid, but only when general DMA is idle. After the engine acknowledges, it holds its active indication for a tail that realigns to the CPU cycle, and then releases the bus.

Top module: `hdma_line_sched`

## Requirements
- R1: A write with `wr_addr_i` equal to 16'h420C loads `wr_data_i` into the enable register, with bit n enabling channel n. Writes to any other address leave the register unchanged.
- R2: A channel takes part in a line only if its enable bit is set and its completed flag is clear. A pulse on `ch_done_i[n]` sets flag n. `frame_start_i` clears all flags. `chan_o` shows the participating set from the trigger onward.
- R3: `pending_o` rises at the first clock edge of a line at which `hcount_i` >= 1104, provided at least one channel participates.
- R4: The trigger fires at most once between two `line_start_i` strobes. The counter staying at or above 1104 causes no second request.
- R5: `mode_o` is 0 (setup) after reset and after `frame_start_i` while the scheduler is idle. It becomes 1 (run) together with `pending_o` and stays unchanged until the acknowledge.
- R6: The participating set is captured at the first edge of the line with `hcount_i` >= 1104 - LEAD (LEAD = 4). An enable write at that edge or later affects only the next line.
- R7: When `dma_busy_i` is low at the trigger, `go_o` rises N = 8 - `dma_phase_i` edges after `pending_o` (phase 0 gives 8). When `dma_busy_i` is high, `go_o` rises with `pending_o` (N = 0).
- R8: `ack_i` is honoured only while `go_o` is high. At that edge `pending_o` and `go_o` fall. An acknowledge at any other time has no effect.
- R9: When `dma_busy_i` is low at the acknowledge, `active_o` stays high for T = `cyc_len_i` - (N mod `cyc_len_i`) more edges. When it is high, `active_o` falls at the acknowledge edge.
- R10: After reset, `pending_o`, `go_o`, `active_o`, `mode_o` and `chan_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcount_i | input | 11 | Horizontal counter in master clocks |
| line_start_i | input | 1 | Scanline start strobe |
| frame_start_i | input | 1 | Frame start strobe, clears completed flags |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| ch_done_i | input | 8 | Per-channel completed pulse from the transfer engine |
| dma_busy_i | input | 1 | General DMA is running |
| dma_phase_i | input | 3 | Current phase within the 8-clock DMA grid |
| cyc_len_i | input | 4 | Length of the current CPU cycle in master clocks |
| ack_i | input | 1 | Transfer engine acknowledge |
| pending_o | output | 1 | Transfer request outstanding |
| mode_o | output | 1 | 0 = setup, 1 = per-line run |
| go_o | output | 1 | Alignment done, engine may start |
| active_o | output | 1 | Scheduler holds the bus |
| chan_o | output | 8 | Channels taking part in this line |

## Verification
The embedded assertions check the cycle-by-cycle invariants on every cycle:
- a request appears only after the trigger position;
- the engine fires at most once per line;
- the mode is held while the request waits;
- `go_o` implies a request;
- the alignment count is bounded;
- the captured set never includes a completed channel.

Only the bench scenarios can show the end-to-end behaviours:
- the exact cut-off of the enable write window, swept in 2-clock steps across the lead;
- the arithmetic of the alignment and tail lengths over every phase, busy state and cycle length;
- the effect of address decoding and completed flags on which channels run.

// File: rtl/hdma_sched_pkg.sv
// Package: shared types of the per-line transfer scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package hdma_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_XFER  = 2'd2,
        ST_TAIL  = 2'd3
    } sched_state_t;

    typedef enum logic {
        MODE_SETUP = 1'b0,
        MODE_RUN   = 1'b1
    } xfer_mode_t;
endpackage

// File: rtl/hdma_enable_regs.sv
// Module: holds the channel-enable register and the per-frame completed
// flags. Captures the participating channel set once per line at the
// early sample position.
// Assumes: line_start precedes the sample position in every line.
module hdma_enable_regs #(
    parameter int              NCH        = 8,
    parameter int              HW         = 11,
    parameter int              AW         = 16,
    parameter logic [AW-1:0]   EN_ADDR    = 16'h420C,
    parameter int              SAMPLE_POS = 1100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HW-1:0]  hcount,
    input  logic           line_start,
    input  logic           frame_start,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [NCH-1:0] wr_data,
    input  logic [NCH-1:0] done,
    output logic [NCH-1:0] snap_o
);
    localparam logic [HW-1:0] SAMPLE_H = HW'(SAMPLE_POS);

    logic [NCH-1:0] en_q;
    logic [NCH-1:0] done_q;
    logic [NCH-1:0] snap_q;
    logic           sampled_q;
    logic           sample_now;

    assign sample_now = !line_start && !sampled_q && (hcount >= SAMPLE_H);
    assign snap_o     = snap_q;

    // Enable register: loaded by a CPU write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                              en_q <= '0;
        else if (wr_en && (wr_addr == EN_ADDR))  en_q <= wr_data;
    end

    // Completed flags: cleared per frame, set per channel by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n)           done_q <= '0;
        else if (frame_start) done_q <= '0;
        else                  done_q <= done_q | done;
    end

    // Early sample: capture enabled-and-not-completed once per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sampled_q <= 1'b0;
            snap_q    <= '0;
        end else if (line_start) begin
            sampled_q <= 1'b0;
            snap_q    <= '0;
        end else if (sample_now) begin
            sampled_q <= 1'b1;
            snap_q    <= en_q & ~done_q;
        end
    end

    assert_snap_excludes_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_now |=> ((snap_q & $past(done_q)) == '0));

    assert_snap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sampled_q && !line_start) |=> $stable(snap_q));
endmodule

// File: rtl/hdma_line_trigger.sv
// Module: fires once per line when the horizontal counter reaches the
// trigger position. It fires only while channels participate and the
// scheduler is idle.
// Assumes: hcount is monotonic within a line.
module hdma_line_trigger #(
    parameter int HW       = 11,
    parameter int TRIG_POS = 1104
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hcount,
    input  logic          line_start,
    input  logic          any_active,
    input  logic          idle,
    output logic          fire_o
);
    localparam logic [HW-1:0] TRIG_H = HW'(TRIG_POS);

    logic triggered_q;
    logic hit;
    logic fired_line_q;

    assign hit    = !line_start && !triggered_q && (hcount >= TRIG_H);
    assign fire_o = hit && any_active && idle;

    // Triggered guard: set on the first hit, cleared by the line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          triggered_q <= 1'b0;
        else if (line_start) triggered_q <= 1'b0;
        else if (hit)        triggered_q <= 1'b1;
    end

    // Checker state: remembers a fire inside the current line.
    always_ff @(posedge clk) begin
        if (!rst_n)          fired_line_q <= 1'b0;
        else if (line_start) fired_line_q <= 1'b0;
        else if (fire_o)     fired_line_q <= 1'b1;
    end

    assert_single_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> !fired_line_q);
endmodule

// File: rtl/hdma_align_timer.sv
// Module: owns the request, mode and active outputs. Pads the start onto
// the DMA grid, waits for the acknowledge, then runs the CPU-cycle tail.
// Assumes: cyc_len is nonzero whenever a tail is needed.
module hdma_align_timer
    import hdma_sched_pkg::*;
#(
    parameter int NCH = 8,
    parameter int PW  = 3,
    parameter int CW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire,
    input  logic [NCH-1:0] chan_in,
    input  logic           frame_start,
    input  logic           dma_busy,
    input  logic [PW-1:0]  dma_phase,
    input  logic [CW-1:0]  cyc_len,
    input  logic           ack,
    output logic           pending_o,
    output logic           mode_o,
    output logic           go_o,
    output logic           active_o,
    output logic           idle_o,
    output logic [NCH-1:0] chan_o
);
    localparam int          CNTW = (CW > PW + 1) ? CW : PW + 1;
    localparam logic [PW:0] GRID = (PW + 1)'(1 << PW);

    sched_state_t   state_q;
    xfer_mode_t     mode_q;
    logic [CNTW-1:0] cnt_q;
    logic [PW:0]    align_q;
    logic [PW:0]    align_n;
    logic [CNTW-1:0] cyc_ext;
    logic [CNTW-1:0] tail_n;
    logic           pending_q;
    logic           active_q;
    logic [NCH-1:0] chan_q;

    // Grid padding and tail length for the current inputs.
    always_comb begin
        align_n = dma_busy ? '0 : (GRID - {1'b0, dma_phase});
        cyc_ext = CNTW'(cyc_len);
        tail_n  = (cyc_ext == '0) ? '0 : (cyc_ext - (CNTW'(align_q) % cyc_ext));
    end

    // Scheduler sequence: idle, align, wait for ack, tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_SETUP;
            cnt_q     <= '0;
            align_q   <= '0;
            pending_q <= 1'b0;
            active_q  <= 1'b0;
            chan_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (fire) begin
                        pending_q <= 1'b1;
                        active_q  <= 1'b1;
                        mode_q    <= MODE_RUN;
                        chan_q    <= chan_in;
                        align_q   <= align_n;
                        cnt_q     <= CNTW'(align_n);
                        state_q   <= (align_n == '0) ? ST_XFER : ST_ALIGN;
                    end else if (frame_start) begin
                        mode_q <= MODE_SETUP;
                    end
                end
                ST_ALIGN: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q <= CNTW'(1)) state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (ack) begin
                        pending_q <= 1'b0;
                        if (dma_busy || (tail_n == '0)) begin
                            active_q <= 1'b0;
                            state_q  <= ST_IDLE;
                        end else begin
                            cnt_q   <= tail_n;
                            state_q <= ST_TAIL;
                        end
                    end
                end
                default: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q <= CNTW'(1)) begin
                        active_q <= 1'b0;
                        state_q  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign pending_o = pending_q;
    assign mode_o    = mode_q;
    assign go_o      = (state_q == ST_XFER);
    assign active_o  = active_q;
    assign idle_o    = (state_q == ST_IDLE);
    assign chan_o    = chan_q;

    assert_go_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> pending_o);

    assert_mode_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !(go_o && ack)) |=> (pending_o && $stable(mode_o) && mode_o == MODE_RUN));

    assert_align_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGN) |-> ((cnt_q != '0) && (cnt_q <= CNTW'(GRID))));

    assert_active_covers_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> active_o);
endmodule

// File: rtl/hdma_line_sched.sv
// Module: top of the per-line transfer trigger scheduler. Samples the
// channel enables LEAD clocks ahead of the trigger position, fires once
// per line and aligns the start to the DMA grid.
// Assumes: hcount_i advances in steps of 2 and line_start_i precedes
// the sample position.
module hdma_line_sched #(
    parameter int            NCH      = 8,
    parameter int            HW       = 11,
    parameter int            AW       = 16,
    parameter logic [AW-1:0] EN_ADDR  = 16'h420C,
    parameter int            TRIG_POS = 1104,
    parameter int            LEAD     = 4,
    parameter int            PW       = 3,
    parameter int            CW       = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HW-1:0]  hcount_i,
    input  logic           line_start_i,
    input  logic           frame_start_i,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [NCH-1:0] wr_data_i,
    input  logic [NCH-1:0] ch_done_i,
    input  logic           dma_busy_i,
    input  logic [PW-1:0]  dma_phase_i,
    input  logic [CW-1:0]  cyc_len_i,
    input  logic           ack_i,
    output logic           pending_o,
    output logic           mode_o,
    output logic           go_o,
    output logic           active_o,
    output logic [NCH-1:0] chan_o
);
    localparam int            SAMPLE_POS = TRIG_POS - LEAD;
    localparam logic [HW-1:0] TRIG_H     = HW'(TRIG_POS);

    logic [NCH-1:0] snap;
    logic           fire;
    logic           idle;

    hdma_enable_regs #(
        .NCH(NCH), .HW(HW), .AW(AW), .EN_ADDR(EN_ADDR), .SAMPLE_POS(SAMPLE_POS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .hcount(hcount_i), .line_start(line_start_i),
        .frame_start(frame_start_i), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .done(ch_done_i), .snap_o(snap)
    );

    hdma_line_trigger #(
        .HW(HW), .TRIG_POS(TRIG_POS)
    ) u_trig (
        .clk(clk), .rst_n(rst_n), .hcount(hcount_i), .line_start(line_start_i),
        .any_active(|snap), .idle(idle), .fire_o(fire)
    );

    hdma_align_timer #(
        .NCH(NCH), .PW(PW), .CW(CW)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .fire(fire), .chan_in(snap),
        .frame_start(frame_start_i), .dma_busy(dma_busy_i), .dma_phase(dma_phase_i),
        .cyc_len(cyc_len_i), .ack(ack_i), .pending_o(pending_o), .mode_o(mode_o),
        .go_o(go_o), .active_o(active_o), .idle_o(idle), .chan_o(chan_o)
    );

    assert_request_after_position_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> ($past(hcount_i) >= TRIG_H));
endmodule

// File: tb/test_hdma_line_sched.sv
// Bench: line-by-line sweeps with expected timing computed arithmetically.
module test_hdma_line_sched;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] hcount;
    logic        line_start, frame_start, wr_en, dma_busy, ack;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data, ch_done, chan_o;
    logic [2:0]  dma_phase;
    logic [3:0]  cyc_len;
    logic        pending_o, mode_o, go_o, active_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int    l_rises, l_np, l_ng, l_na, l_hrise;
    logic [7:0] l_chan;
    logic  l_mode, l_mode_first;

    always #5 clk = ~clk;

    hdma_line_sched i_hdma_line_sched (
        .clk(clk), .rst_n(rst_n), .hcount_i(hcount), .line_start_i(line_start),
        .frame_start_i(frame_start), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .ch_done_i(ch_done), .dma_busy_i(dma_busy),
        .dma_phase_i(dma_phase), .cyc_len_i(cyc_len), .ack_i(ack),
        .pending_o(pending_o), .mode_o(mode_o), .go_o(go_o), .active_o(active_o),
        .chan_o(chan_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One scanline from h=1080 to 1180 in 2-clock steps, ack held high.
    task automatic run_line(input int wh, input logic [15:0] waddr, input logic [7:0] wd,
                            input logic [7:0] dm, input logic fs, input logic busy,
                            input logic [2:0] ph, input logic [3:0] cy);
        logic prev_p = 1'b0;
        l_rises = 0; l_np = 0; l_ng = 0; l_na = 0; l_hrise = -1;
        l_chan = '0; l_mode = 1'b0; l_mode_first = 1'b0;
        for (int h = 1080; h <= 1180; h += 2) begin
            hcount      = 11'(h);
            line_start  = (h == 1080);
            frame_start = fs && (h == 1080);
            wr_en       = (h == wh);
            wr_addr     = waddr;
            wr_data     = wd;
            ch_done     = (h == 1080) ? dm : 8'h00;
            dma_busy    = busy;
            dma_phase   = ph;
            cyc_len     = cy;
            ack         = 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (h == 1080) l_mode_first = mode_o;
            if (pending_o && !prev_p) begin
                l_rises++;
                l_chan  = chan_o;
                l_mode  = mode_o;
                l_hrise = h;
            end
            prev_p = pending_o;
            if (pending_o) l_np++;
            if (go_o)      l_ng++;
            if (active_o)  l_na++;
        end
        wr_en = 1'b0;
    endtask

    // Expected results of a line that fires.
    task automatic expect_fire(input string tag, input logic [7:0] ch, input logic busy,
                               input logic [2:0] ph, input logic [3:0] cy);
        int n = busy ? 0 : 8 - int'(ph);
        int t = busy ? 0 : int'(cy) - (n % int'(cy));
        chk(l_rises == 1, {tag, " R4 single request"}, l_rises, 1);
        chk(l_hrise == 1104, {tag, " R3 request position"}, l_hrise, 1104);
        chk(l_chan == ch, {tag, " R2 channel set"}, int'(l_chan), int'(ch));
        chk(l_mode == 1'b1, {tag, " R5 run mode"}, int'(l_mode), 1);
        chk(l_np == n + 1, {tag, " R7 R8 pending length"}, l_np, n + 1);
        chk(l_ng == 1, {tag, " R8 go length"}, l_ng, 1);
        chk(l_na == n + 1 + t, {tag, " R9 active length"}, l_na, n + 1 + t);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hcount = '0; line_start = 0; frame_start = 0; wr_en = 0;
        wr_addr = '0; wr_data = '0; ch_done = '0; dma_busy = 0; dma_phase = '0;
        cyc_len = 4'd6; ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk({pending_o, go_o, active_o, mode_o} == 4'b0, "R10 reset outputs",
            int'({pending_o, go_o, active_o, mode_o}), 0);
        chk(chan_o == 8'h00, "R10 reset chan", int'(chan_o), 0);
        rst_n = 1'b1;

        // R1 nothing enabled after reset: no request
        run_line(0, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 4'd6);
        chk(l_na == 0, "R1 idle with no enables", l_na, 0);

        // Full sweep: phase x busy x cycle length (R7, R9)
        run_line(1080, 16'h420C, 8'hFF, 8'h00, 1'b1, 1'b0, 3'd0, 4'd6);
        for (int b = 0; b < 2; b++)
            for (int p = 0; p < 8; p++)
                for (int c = 0; c < 3; c++) begin
                    logic [3:0] cy = (c == 0) ? 4'd6 : (c == 1) ? 4'd8 : 4'd12;
                    run_line(0, 16'h0000, 8'h00, 8'h00, 1'b1, b[0], 3'(p), cy);
                    chk(l_mode_first == 1'b0, "R5 setup after frame start", int'(l_mode_first), 0);
                    expect_fire("sweep R7", 8'hFF, b[0], 3'(p), cy);
                end

        // R6 write position sweep across the lead window
        for (int wp = 1090; wp <= 1110; wp += 2) begin
            run_line(1080, 16'h420C, 8'h00, 8'h00, 1'b1, 1'b0, 3'd3, 4'd6);
            chk(l_rises == 0, "R1 cleared enables no request", l_rises, 0);
            run_line(wp, 16'h420C, 8'h5A, 8'h00, 1'b0, 1'b0, 3'd3, 4'd6);
            chk(l_rises == ((wp <= 1098) ? 1 : 0), "R6 same-line effect", l_rises,
                (wp <= 1098) ? 1 : 0);
            run_line(0, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0, 3'd3, 4'd6);
            expect_fire("R6 next line", 8'h5A, 1'b0, 3'd3, 4'd6);
        end

        // R1 bit-to-channel mapping, one channel at a time
        for (int n = 0; n < 8; n++) begin
            run_line(1080, 16'h420C, 8'(1 << n), 8'h00, 1'b1, 1'b1, 3'd0, 4'd8);
            expect_fire("R1 single channel", 8'(1 << n), 1'b1, 3'd0, 4'd8);
        end

        // R1 other address ignored
        run_line(1080, 16'h420C, 8'hFF, 8'h00, 1'b1, 1'b1, 3'd0, 4'd8);
        run_line(1080, 16'h420D, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 4'd8);
        expect_fire("R1 wrong address", 8'hFF, 1'b1, 3'd0, 4'd8);
        chk(l_mode_first == 1'b1, "R5 mode kept without frame start", int'(l_mode_first), 1);

        // R2 completed flags
        run_line(0, 16'h0000, 8'h00, 8'h08, 1'b0, 1'b1, 3'd0, 4'd8);
        expect_fire("R2 one completed", 8'hF7, 1'b1, 3'd0, 4'd8);
        run_line(0, 16'h0000, 8'h00, 8'hF7, 1'b0, 1'b1, 3'd0, 4'd8);
        chk(l_rises == 0, "R2 all completed no request", l_rises, 0);
        chk(l_na == 0, "R2 all completed no active", l_na, 0);
        run_line(0, 16'h0000, 8'h00, 8'h00, 1'b1, 1'b1, 3'd0, 4'd8);
        expect_fire("R2 frame start clears", 8'hFF, 1'b1, 3'd0, 4'd8);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule